// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog for system supervision. Software programs a timeout period, releases the halt bit and then reloads the timer at regular intervals. The count drops by one on each tick-enable pulse. When the count runs out the first time, a status flag is set, an optional one-clock event pulse goes out to the interrupt logic and the count starts again from the period. If the count runs out a second time with no service in between, a second status flag is set and a system-reset request is raised and held. A no-reboot strap input blocks that reset request. When the strap is set, the timer goes back to first-stage behaviour instead.

A controller FSM sets the order of events. Its states are HALTED, ARMED, WARNED and TRIPPED. The state register resets to HALTED. A control write that clears the halt bit moves HALTED to ARMED. A control write that sets the halt bit moves ARMED or WARNED to HALTED. A first expiry moves ARMED to WARNED. A reload write, or any control write, moves WARNED back to ARMED. A second expiry moves WARNED to TRIPPED when the strap is clear, and to ARMED when it is set. TRIPPED is left only through reset.

A parameter selects the variant. The wide variant has a 16-bit register word and a 10-bit period, with a legal period range of 2 to 613 ticks. The legacy variant has an 8-bit word and a 6-bit period, with a legal range of 4 to 39 ticks. Software enforces the range; the hardware does not check it.

Top module: `dual_stage_wdt`

## Requirements
- R1: After reset the registers read as follows. Address 0 (control) bit 0, the halt bit, reads 1. Address 1 reads the variant's maximum period, 613 wide or 39 legacy. Address 2 reads the current count, which equals that same maximum. Address 3 bit 0 (first-timeout flag) reads 0. Address 4 bit 0 (second-timeout flag) reads 0 and address 4 bit 1 (boot flag) reads 1, so address 4 reads 2. timeout_evt and sys_rst_req are 0.
- R2: A write to address 1 stores the low period bits exactly as written, including values outside the legal range such as 0 and 1. The upper bits of the register word ignore writes and always read 0.
- R3: While the halt bit is 1, ticks do not change the count. After a control write clears the halt bit, counting resumes from the frozen value.
- R4: A write of any data to address 2 loads the count with the stored period at the next clock edge.
- R5: Each tick decrements the count. A tick that finds the count at 1 or 0 is an expiry and reloads the period, so an expiry comes exactly `period` ticks after a reload.
- R6: On a first expiry, address 3 bit 0 is set. In the next cycle timeout_evt is 1 for exactly one clock, but only if evt_global_en and evt_wdog_en are both 1.
- R7: A second expiry with no service in between sets address 4 bit 0. With no_reboot_strap at 0, sys_rst_req rises and stays high until reset, and the count freezes.
- R8: With no_reboot_strap at 1, sys_rst_req never rises. The next expiry after a second expiry counts as a first expiry again.
- R9: The flags at address 3 bit 0, address 4 bit 0 and address 4 bit 1 clear only when a 1 is written to their bit position. Writing 0 leaves them unchanged.
- R10: A reload write or any control write clears the record of a first expiry, so the next expiry is again a first expiry.
- R11: If a control or reload write falls in the same cycle as a tick, that tick is dropped. A tick at count 1 therefore causes no expiry.
- R12: The WIDE_MODE parameter selects the variant. With 1 the word is 16 bits and the period 10 bits. With 0 the word is 8 bits and the period 6 bits, so a write of 8'hFF reads back 8'h3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-clock tick pulse that advances the countdown |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | REG_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | REG_W | Combinational read data |
| no_reboot_strap | input | 1 | When 1, the reset request is suppressed |
| evt_global_en | input | 1 | Global enable for the timeout event |
| evt_wdog_en | input | 1 | Watchdog enable for the timeout event |
| timeout_evt | output | 1 | One-clock pulse after a first expiry |
| sys_rst_req | output | 1 | Held system-reset request |

## Verification
If the controller held a wrong state, the fault would show up at the first expiry that follows. A stale first-expiry record turns an expected timeout_evt pulse into a sys_rst_req assertion, or the reverse, within `period` ticks. A counter fault shows up in the next cycle, because the count is readable at address 2 and the bench compares it with a reference model on every clock. Flag bits are compared in the same way, so a missed set or a wrong clear is visible one cycle after the edge that caused it.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT1  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_STAT2  = 3'd4;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_ARMED   = 2'd1,
        ST_WARNED  = 2'd2,
        ST_TRIPPED = 2'd3
    } wdt_state_e;

    function automatic int word_bits(bit wide);
        return wide ? 16 : 8;
    endfunction

    function automatic int period_bits(bit wide);
        return wide ? 10 : 6;
    endfunction

    function automatic int period_reset(bit wide);
        return wide ? 613 : 39;
    endfunction

endpackage

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int REG_W   = 16,
    parameter int PER_W   = 10,
    parameter int PER_RST = 613
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              set_first,
    input  logic              set_second,
    input  logic [PER_W-1:0]  count,
    output logic              halt,
    output logic [PER_W-1:0]  period
);

    logic             halt_q;
    logic [PER_W-1:0] per_q;
    logic             first_q;
    logic             second_q;
    logic             boot_q;

    logic wr_ctrl, wr_per, wr_st1, wr_st2;
    logic unused_wr_hi;

    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_per  = wr_en && (wr_addr == ADDR_PERIOD);
    assign wr_st1  = wr_en && (wr_addr == ADDR_STAT1);
    assign wr_st2  = wr_en && (wr_addr == ADDR_STAT2);

    // upper word bits are read-only zero
    assign unused_wr_hi = ^wr_data[REG_W-1:PER_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= 1'b1;
            per_q  <= PER_W'(PER_RST);
        end else begin
            if (wr_ctrl) halt_q <= wr_data[0];
            if (wr_per)  per_q  <= wr_data[PER_W-1:0];
        end
    end

    // sticky flags: a set event wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b0;
            second_q <= 1'b0;
            boot_q   <= 1'b1;
        end else begin
            first_q  <= set_first  || (first_q  && !(wr_st1 && wr_data[0]));
            second_q <= set_second || (second_q && !(wr_st2 && wr_data[0]));
            boot_q   <= boot_q && !(wr_st2 && wr_data[1]);
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_CTRL:   rd_data = REG_W'(halt_q);
            ADDR_PERIOD: rd_data = REG_W'(per_q);
            ADDR_RELOAD: rd_data = REG_W'(count);
            ADDR_STAT1:  rd_data = REG_W'(first_q);
            ADDR_STAT2:  rd_data = REG_W'({boot_q, second_q});
            default:     rd_data = '0;
        endcase
    end

    assign halt   = halt_q;
    assign period = per_q;

endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
    parameter int PER_W   = 10,
    parameter int PER_RST = 613
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] count,
    output logic             expire
);

    logic [PER_W-1:0] cnt_q;

    assign expire = advance && (cnt_q <= PER_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= PER_W'(PER_RST);
        end else if (load || expire) begin
            cnt_q <= period;
        end else if (advance) begin
            cnt_q <= cnt_q - PER_W'(1);
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/wdt2_fsm.sv
module wdt2_fsm
    import wdt2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic halt_val,
    input  logic reload_wr,
    input  logic expire,
    input  logic no_reboot,
    input  logic gl_en,
    input  logic wd_en,
    output logic running,
    output logic first_hit,
    output logic second_hit,
    output logic evt_out,
    output logic rst_req
);

    wdt_state_e state_q, state_n;

    assign running    = (state_q == ST_ARMED) || (state_q == ST_WARNED);
    assign first_hit  = expire && (state_q == ST_ARMED);
    assign second_hit = expire && (state_q == ST_WARNED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALTED;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (ctrl_wr && !halt_val) state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctrl_wr && halt_val) state_n = ST_HALTED;
                else if (expire)         state_n = ST_WARNED;
            end
            ST_WARNED: begin
                if (ctrl_wr)        state_n = halt_val ? ST_HALTED : ST_ARMED;
                else if (reload_wr) state_n = ST_ARMED;
                else if (expire)    state_n = no_reboot ? ST_ARMED : ST_TRIPPED;
            end
            ST_TRIPPED: state_n = ST_TRIPPED;
            default:    state_n = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_out <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            evt_out <= first_hit && gl_en && wd_en;
            rst_req <= (state_n == ST_TRIPPED);
        end
    end

endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
    import wdt2_pkg::*;
#(
    parameter bit WIDE_MODE = 1'b1,
    localparam int REG_W   = word_bits(WIDE_MODE),
    localparam int PER_W   = period_bits(WIDE_MODE),
    localparam int PER_RST = period_reset(WIDE_MODE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              no_reboot_strap,
    input  logic              evt_global_en,
    input  logic              evt_wdog_en,
    output logic              timeout_evt,
    output logic              sys_rst_req
);

    logic             ctrl_wr, reload_wr, service;
    logic             halt_w, run_w, advance_w, expire_w;
    logic             first_w, second_w;
    logic [PER_W-1:0] period_w, cnt_w;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign reload_wr = wr_en && (wr_addr == ADDR_RELOAD);
    assign service   = ctrl_wr || reload_wr;
    assign advance_w = run_w && tick_en && !service;

    wdt2_regs #(.REG_W(REG_W), .PER_W(PER_W), .PER_RST(PER_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .set_first  (first_w),
        .set_second (second_w),
        .count      (cnt_w),
        .halt       (halt_w),
        .period     (period_w)
    );

    wdt2_counter #(.PER_W(PER_W), .PER_RST(PER_RST)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (reload_wr),
        .advance (advance_w),
        .period  (period_w),
        .count   (cnt_w),
        .expire  (expire_w)
    );

    wdt2_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .halt_val   (wr_data[0]),
        .reload_wr  (reload_wr),
        .expire     (expire_w),
        .no_reboot  (no_reboot_strap),
        .gl_en      (evt_global_en),
        .wd_en      (evt_wdog_en),
        .running    (run_w),
        .first_hit  (first_w),
        .second_hit (second_w),
        .evt_out    (timeout_evt),
        .rst_req    (sys_rst_req)
    );

endmodule

// File: rtl/dual_stage_wdt_chk.sv
module dual_stage_wdt_chk
    import wdt2_pkg::*;
#(
    parameter int PER_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              strap,
    input logic              gl_en,
    input logic              wd_en,
    input logic              evt,
    input logic              rst_req,
    input logic              halt,
    input logic [PER_W-1:0]  cnt
);

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt); // R6

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(gl_en && wd_en)); // R6

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req); // R7

    AST_TRIP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !(wr_en && wr_addr == ADDR_RELOAD)) |=> $stable(cnt)); // R7

    AST_STRAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !$past(strap)); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !(wr_en && wr_addr == ADDR_RELOAD)) |=> $stable(cnt)); // R3

endmodule

bind dual_stage_wdt dual_stage_wdt_chk #(.PER_W(PER_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .strap   (no_reboot_strap),
    .gl_en   (evt_global_en),
    .wd_en   (evt_wdog_en),
    .evt     (timeout_evt),
    .rst_req (sys_rst_req),
    .halt    (halt_w),
    .cnt     (cnt_w)
);

// File: tb/dual_stage_wdt_bench.sv
module dual_stage_wdt_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [2:0]  rd_addr = 3'd2;
    logic        strap = 1'b0;
    logic        gl_en = 1'b1;
    logic        wd_en = 1'b1;
    logic [15:0] rd_data;
    logic [7:0]  rd_data_l;
    logic        evt, rst_req, evt_l, rst_req_l;

    int errors = 0;
    int checks = 0;
    int evt_seen = 0;
    bit done = 1'b0;

    // reference model state
    int m_halt, m_per, m_cnt, m_st1, m_st2, m_boot, m_warned, m_trip, m_evt;

    always #5 clk = ~clk;

    dual_stage_wdt #(.WIDE_MODE(1'b1)) u_dual_stage_wdt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .no_reboot_strap(strap), .evt_global_en(gl_en), .evt_wdog_en(wd_en),
        .timeout_evt(evt), .sys_rst_req(rst_req)
    );

    dual_stage_wdt #(.WIDE_MODE(1'b0)) u_dual_stage_wdt_legacy (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[7:0]),
        .rd_addr(rd_addr), .rd_data(rd_data_l),
        .no_reboot_strap(strap), .evt_global_en(gl_en), .evt_wdog_en(wd_en),
        .timeout_evt(evt_l), .sys_rst_req(rst_req_l)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    function automatic int model_read(int a);
        case (a)
            0: return m_halt;
            1: return m_per;
            2: return m_cnt;
            3: return m_st1;
            4: return m_boot * 2 + m_st2;
            default: return 0;
        endcase
    endfunction

    task automatic model_clock();
        int ctrl, rld, running, adv, expire, first, second;
        if (!rst_n) begin
            m_halt = 1; m_per = 613; m_cnt = 613; m_st1 = 0; m_st2 = 0;
            m_boot = 1; m_warned = 0; m_trip = 0; m_evt = 0;
            return;
        end
        ctrl    = (wr_en && wr_addr == 0);
        rld     = (wr_en && wr_addr == 2);
        running = (!m_halt && !m_trip);
        adv     = (running && tick_en && !(ctrl || rld));
        expire  = (adv && m_cnt <= 1);
        first   = (expire && !m_warned);
        second  = (expire && m_warned);
        m_evt   = (first && gl_en && wd_en);
        if (rld || expire) m_cnt = m_per;
        else if (adv)      m_cnt = m_cnt - 1;
        if (!m_trip) begin
            if (ctrl || rld) m_warned = 0;
            else if (first)  m_warned = 1;
            else if (second) begin
                m_warned = 0;
                if (!strap) m_trip = 1;
            end
        end
        m_st1  = (first  || (m_st1 && !(wr_en && wr_addr == 3 && wr_data[0]))) ? 1 : 0;
        m_st2  = (second || (m_st2 && !(wr_en && wr_addr == 4 && wr_data[0]))) ? 1 : 0;
        m_boot = (m_boot && !(wr_en && wr_addr == 4 && wr_data[1])) ? 1 : 0;
        if (ctrl) m_halt = int'(wr_data[0]);
        if (wr_en && wr_addr == 1) m_per = int'(wr_data[9:0]);
    endtask

    task automatic step();
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check("R6 timeout_evt vs model", int'(evt), m_evt);
        check("R7 sys_rst_req vs model", int'(rst_req), m_trip);
        check("R5 read data vs model", int'(rd_data), model_read(int'(rd_addr)));
        if (evt) evt_seen++;
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        tick_en = 1'b1;
        for (int i = 0; i < n; i++) step();
        tick_en = 1'b0;
    endtask

    task automatic rd_check(string tag, int a, int expected);
        rd_addr = 3'(a);
        #1;
        check(tag, int'(rd_data), expected);
        rd_addr = 3'd2;
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        do_reset();
        // R1 reset state
        rd_check("R1 halt", 0, 1);
        rd_check("R1 period", 1, 613);
        rd_check("R1 count", 2, 613);
        rd_check("R1 stat1", 3, 0);
        rd_check("R1 stat2 boot", 4, 2);
        check("R1 evt", int'(evt), 0);
        check("R1 rst", int'(rst_req), 0);
        rd_addr = 3'd1; #1;
        check("R12 legacy reset period", int'(rd_data_l), 39);
        rd_addr = 3'd2; #1;

        // R4 R5 R6 R7: two expiries, strap clear
        wr(1, 5); wr(2, 16'hBEEF);
        rd_check("R4 reload count", 2, 5);
        wr(0, 0);
        evt_seen = 0;
        ticks(4);
        rd_check("R5 no expiry yet", 3, 0);
        ticks(1);
        rd_check("R5 expiry after period", 3, 1);
        check("R6 one event", evt_seen, 1);
        ticks(5);
        check("R7 reset request", int'(rst_req), 1);
        rd_check("R7 second flag", 4, 3);
        ticks(3);
        check("R7 reset held", int'(rst_req), 1);
        rd_check("R7 count frozen", 2, 5);

        // R8 strap set
        do_reset();
        strap = 1'b1;
        wr(1, 3); wr(2, 0); wr(0, 0);
        evt_seen = 0;
        ticks(6);
        check("R8 no reset", int'(rst_req), 0);
        rd_check("R8 second flag", 4, 3);
        check("R8 events", evt_seen, 1);
        ticks(3);
        check("R8 first again", evt_seen, 2);

        // R9 write-one-to-clear
        wr(3, 0); rd_check("R9 stat1 kept", 3, 1);
        wr(3, 1); rd_check("R9 stat1 cleared", 3, 0);
        wr(4, 0); rd_check("R9 stat2 kept", 4, 3);
        wr(4, 1); rd_check("R9 second cleared", 4, 2);
        wr(4, 2); rd_check("R9 boot cleared", 4, 0);

        // R3 halt
        ticks(1);
        wr(0, 1);
        ticks(4);
        rd_check("R3 frozen", 2, 2);
        wr(0, 0);
        ticks(1);
        rd_check("R3 resumed", 2, 1);

        // R10 reload clears first-expiry record
        strap = 1'b0;
        evt_seen = 0;
        ticks(1);
        wr(2, 0);
        ticks(3);
        check("R10 first again", evt_seen, 2);
        check("R10 no reset", int'(rst_req), 0);

        // R11 service in same cycle as tick
        ticks(2);
        tick_en = 1'b1; wr(0, 0); tick_en = 1'b0;
        rd_check("R11 tick dropped", 2, 1);
        ticks(1);
        check("R11 first not second", int'(rst_req), 0);
        check("R11 event", evt_seen, 3);

        // R6 enables
        wr(3, 1);
        gl_en = 1'b0;
        wr(2, 0);
        ticks(3);
        rd_check("R6 flag set without event", 3, 1);
        check("R6 global gate", evt_seen, 3);
        gl_en = 1'b1; wd_en = 1'b0;
        wr(0, 0);
        ticks(3);
        check("R6 watchdog gate", evt_seen, 3);
        wd_en = 1'b1;

        // R2 period stored raw, upper bits ignored
        strap = 1'b1;
        wr(1, 16'hFC01);
        rd_check("R2 upper bits ignored", 1, 1);
        wr(2, 0);
        ticks(4);
        check("R2 period one", evt_seen, 5);
        wr(1, 0);
        rd_check("R2 period zero", 1, 0);
        wr(1, 16'h00FF);
        rd_check("R12 wide period", 1, 16'hFF);
        rd_addr = 3'd1; #1;
        check("R12 legacy masks", int'(rd_data_l), 8'h3F);
        rd_addr = 3'd2; #1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule